// File: doc/BRIEF.md
# Pseudo-Noise Sync Code Correlator

This block keeps several devices on a shared timing reference by means of a repeating pseudo-noise chip sequence. On the master, the block sends a 31-chip maximal-length code, one chip per clock, on a serial output. On a slave, the block shifts the received serial chips into a 31-chip window and scores the window against the expected code. When the score reaches a programmable threshold, the slave declares lock and marks each code boundary with a one-cycle alignment pulse for downstream logic.

The code is spread over many chips, so a few corrupted chips lower the score without breaking lock. The threshold trades noise tolerance against resistance to false lock. A sticky flag records any loss of lock until software clears it. Software reaches control, threshold and status through a small register port with single-cycle writes and a combinational read.

Top module: `pn_sync_corr`

## Requirements
- R1: After reset, the control word reads 0 and the threshold reads 16. Status reads 0, and `sync_o`, `lock_o` and `align_o` are 0.
- R2: The register map is as follows. Address 0 is control: bit 0 feature enable, bit 1 code-mode select, bit 2 pulse-mode enable, bit 3 receive enable, bit 4 transmit enable. Address 1 holds the 5-bit threshold in bits [4:0]. Address 2 is status: bit 0 lock (read-only), bit 1 lock-lost (read-only), bit 2 clear-request (read/write). Unused bits read 0 and ignore writes.
- R3: The code function is active only when the feature enable is 1, the code-mode select is 1 and the pulse-mode enable is 0. Otherwise `sync_o` stays 0 and lock never sets.
- R4: When the function is active and transmit is enabled, `sync_o` starts in the cycle after the enabling write. It emits chips c[0..4] = 0,0,0,0,1, then c[n] = c[n-5] xor c[n-3], repeating every 31 chips. With transmit disabled, `sync_o` is 0.
- R5: When receive is active, every clock shifts `sync_i` into a window that holds the last 31 chips. The score is (agreeing chips - 15) clamped to 0..16. While unlocked, the score is tested on every cycle, and lock sets when score >= threshold.
- R6: `align_o` is a one-cycle pulse. It appears two clocks after the clock in which the last chip of a code period is presented, and only if that period's score meets the threshold. On acquisition, `lock_o` rises in the same cycle as the pulse.
- R7: While locked, the score is re-tested only at code boundaries, once every 31 chips. Lock holds if score >= threshold and drops otherwise. With threshold 16 one bad chip drops lock. With threshold 12, up to 4 bad chips per period keep it, and 5 drop it.
- R8: Lock-lost sets when a boundary test drops lock. It stays 1 through a later relock. Writing 1 to the clear-request bit alone does not clear it; the following write of 0 clears it.
- R9: Turning receive off clears lock and the window without setting lock-lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one chip per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| sync_i | input | 1 | Received serial sync chips |
| sync_o | output | 1 | Transmitted serial sync chips |
| lock_o | output | 1 | Correlation lock |
| align_o | output | 1 | Code boundary pulse while matching |

## Verification
The correlator is driven with the following patterns:
- Clean repeating code, to show acquisition timing and a pulse on every boundary.
- One bad chip per period at the top threshold, which separates strict matching from tolerant matching.
- Periods of 3, 4 and 5 bad chips at threshold 12, which pin down the exact clamp and compare boundary.
- A clean code fed while the enable combination is wrong, which tells gating apart from correlation.

The transmit chips are compared against an independently built recurrence for two full periods, which detects both wrong taps and a wrong starting phase.

// File: rtl/pn_sync_pkg.sv
package pn_sync_pkg;

  localparam int unsigned STEP_W = 16;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_THR  = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;

  // bit 0 is sync_en
  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic pulse_en;
    logic pn_mode;
    logic sync_en;
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam int unsigned STAT_W   = 3;
  localparam int unsigned STAT_CLR = 2;

  // shift left, feedback into bit 0, output taken from the top bit
  function automatic logic [STEP_W-1:0] lfsr_next(logic [STEP_W-1:0] s,
                                                  logic [STEP_W-1:0] taps,
                                                  int unsigned       w);
    logic             fb;
    logic [STEP_W-1:0] mask;
    fb   = ^(s & taps);
    mask = (STEP_W'(1) << w) - STEP_W'(1);
    return ((s << 1) | STEP_W'(fb)) & mask;
  endfunction

endpackage

// File: rtl/pn_code_gen.sv
module pn_code_gen
  import pn_sync_pkg::*;
#(
  parameter int unsigned        LFSR_W = 5,
  parameter logic [LFSR_W-1:0]  TAPS   = 5'b10100,
  parameter logic [LFSR_W-1:0]  SEED   = 5'b00001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic chip_o
);

  logic [LFSR_W-1:0] state_q;
  logic [STEP_W-1:0] step_w;
  logic              unused_step;

  assign step_w      = lfsr_next(STEP_W'(state_q), STEP_W'(TAPS), LFSR_W);
  assign unused_step = ^step_w[STEP_W-1:LFSR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (!run_i) state_q <= SEED;
    else             state_q <= step_w[LFSR_W-1:0];
  end

  assign chip_o = state_q[LFSR_W-1];

  // all-zero state would freeze the code
  assert_state_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

endmodule

// File: rtl/pn_correlator.sv
module pn_correlator
  import pn_sync_pkg::*;
#(
  parameter int unsigned        LFSR_W = 5,
  parameter logic [LFSR_W-1:0]  TAPS   = 5'b10100,
  parameter logic [LFSR_W-1:0]  SEED   = 5'b00001,
  localparam int unsigned CODE_LEN  = (1 << LFSR_W) - 1,
  localparam int unsigned OFFSET    = (CODE_LEN - 1) / 2,
  localparam int unsigned SCORE_MAX = CODE_LEN - OFFSET,
  localparam int unsigned SCORE_W   = $clog2(SCORE_MAX + 1),
  localparam int unsigned CNT_W     = $clog2(CODE_LEN + 1),
  localparam int unsigned PH_W      = $clog2(CODE_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               chip_i,
  input  logic [SCORE_W-1:0] thr_i,
  output logic               lock_o,
  output logic               align_o,
  output logic               loss_o
);

  function automatic logic [CODE_LEN-1:0] build_ref();
    logic [STEP_W-1:0]   s;
    logic [CODE_LEN-1:0] r;
    s = STEP_W'(SEED);
    r = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      r[CODE_LEN-1-k] = s[LFSR_W-1];
      s = lfsr_next(s, STEP_W'(TAPS), LFSR_W);
    end
    return r;
  endfunction

  localparam logic [CODE_LEN-1:0] REF = build_ref();

  logic [CODE_LEN-1:0] win_q;
  logic [CODE_LEN-1:0] match;
  logic [CNT_W-1:0]    agree;
  logic [CNT_W-1:0]    excess;
  logic [SCORE_W-1:0]  score;
  logic [PH_W-1:0]     ph_q;
  logic                lock_q, align_q, loss_q;
  logic                bnd, hit;

  // oldest chip sits in the top bit
  for (genvar g = 0; g < CODE_LEN; g++) begin : g_cmp
    assign match[g] = ~(win_q[g] ^ REF[g]);
  end

  always_comb begin
    agree = '0;
    for (int i = 0; i < CODE_LEN; i++) agree = agree + CNT_W'(match[i]);
  end

  always_comb begin
    excess = '0;
    score  = '0;
    if (agree > CNT_W'(OFFSET)) begin
      excess = agree - CNT_W'(OFFSET);
      score  = (excess > CNT_W'(SCORE_MAX)) ? SCORE_W'(SCORE_MAX)
                                            : SCORE_W'(excess);
    end
  end

  assign hit = score >= thr_i;
  assign bnd = ~lock_q | (ph_q == PH_W'(CODE_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      ph_q    <= '0;
      lock_q  <= 1'b0;
      align_q <= 1'b0;
      loss_q  <= 1'b0;
    end else if (!run_i) begin
      win_q   <= '0;
      ph_q    <= '0;
      lock_q  <= 1'b0;
      align_q <= 1'b0;
      loss_q  <= 1'b0;
    end else begin
      win_q   <= {win_q[CODE_LEN-2:0], chip_i};
      align_q <= bnd & hit;
      loss_q  <= bnd & lock_q & ~hit;
      if (bnd) begin
        lock_q <= hit;
        ph_q   <= '0;
      end else begin
        ph_q   <= ph_q + PH_W'(1);
      end
    end
  end

  assign lock_o  = lock_q;
  assign align_o = align_q;
  assign loss_o  = loss_q;

  assert_align_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_q |=> !align_q);

  assert_acquire_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> align_q);

  assert_loss_on_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_q |-> (!lock_q && $past(lock_q)));

  assert_idle_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!lock_q && !loss_q));

endmodule

// File: rtl/pn_sync_regs.sv
module pn_sync_regs
  import pn_sync_pkg::*;
#(
  parameter int unsigned      DATA_W  = 16,
  parameter int unsigned      ADDR_W  = 2,
  parameter int unsigned      THR_W   = 5,
  parameter logic [THR_W-1:0] THR_RST = 5'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [THR_W-1:0]  thr_o,
  input  logic              lock_i,
  input  logic              loss_i
);

  ctrl_t            ctrl_q;
  logic [THR_W-1:0] thr_q;
  logic             clr_q, lost_q;
  logic             wr_ctrl, wr_thr, wr_stat, clear_evt;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  assign wr_ctrl   = we_i & (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_thr    = we_i & (addr_i == ADDR_W'(ADDR_THR));
  assign wr_stat   = we_i & (addr_i == ADDR_W'(ADDR_STAT));
  // clear on the 1 -> 0 write of the request bit
  assign clear_evt = wr_stat & clr_q & ~wdata_i[STAT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= THR_RST;
      clr_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_thr)  thr_q  <= wdata_i[THR_W-1:0];
      if (wr_stat) clr_q  <= wdata_i[STAT_CLR];
      if (loss_i)         lost_q <= 1'b1;
      else if (clear_evt) lost_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADDR_CTRL): rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(ADDR_THR):  rdata_o[THR_W-1:0]  = thr_q;
      ADDR_W'(ADDR_STAT): rdata_o[STAT_W-1:0] = {clr_q, lost_q, lock_i};
      default:            rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign thr_o  = thr_q;

  assert_lost_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_i |=> lost_q);

  assert_lost_no_clear_on_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_q && !(we_i && addr_i == ADDR_W'(ADDR_STAT) && !wdata_i[STAT_CLR])) |=> lost_q);

endmodule

// File: rtl/pn_sync_corr.sv
module pn_sync_corr
  import pn_sync_pkg::*;
#(
  parameter int unsigned       DATA_W = 16,
  parameter int unsigned       ADDR_W = 2,
  parameter int unsigned       LFSR_W = 5,
  parameter logic [LFSR_W-1:0] TAPS   = 5'b10100,
  parameter logic [LFSR_W-1:0] SEED   = 5'b00001,
  localparam int unsigned CODE_LEN  = (1 << LFSR_W) - 1,
  localparam int unsigned SCORE_MAX = CODE_LEN - (CODE_LEN - 1) / 2,
  localparam int unsigned THR_W     = $clog2(SCORE_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sync_i,
  output logic              sync_o,
  output logic              lock_o,
  output logic              align_o
);

  ctrl_t            ctrl;
  logic [THR_W-1:0] thr;
  logic             pn_active, tx_run, rx_run;
  logic             chip, lock, loss;

  assign pn_active = ctrl.sync_en & ctrl.pn_mode & ~ctrl.pulse_en;
  assign tx_run    = pn_active & ctrl.tx_en;
  assign rx_run    = pn_active & ctrl.rx_en;

  pn_sync_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .THR_W  (THR_W),
    .THR_RST(THR_W'(SCORE_MAX))
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .we_i   (reg_we_i),
    .rdata_o(reg_rdata_o),
    .ctrl_o (ctrl),
    .thr_o  (thr),
    .lock_i (lock),
    .loss_i (loss)
  );

  pn_code_gen #(
    .LFSR_W(LFSR_W),
    .TAPS  (TAPS),
    .SEED  (SEED)
  ) u_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (tx_run),
    .chip_o(chip)
  );

  pn_correlator #(
    .LFSR_W(LFSR_W),
    .TAPS  (TAPS),
    .SEED  (SEED)
  ) u_corr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (rx_run),
    .chip_i (sync_i),
    .thr_i  (thr),
    .lock_o (lock),
    .align_o(align_o),
    .loss_o (loss)
  );

  assign sync_o = tx_run & chip;
  assign lock_o = lock;

  assert_gate_tx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pn_active && $past(!pn_active)) |-> !sync_o);

  assert_gate_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rx_run) |-> !lock_o);

endmodule

// File: tb/pn_sync_corr_tb_top.sv
`timescale 1ns/1ps
module pn_sync_corr_tb_top;

  typedef struct {
    int cyc;
    bit al;
    bit lk;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        sync_i = 1'b0;
  logic        sync_o, lock_o, align_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  bit   code [31];
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pn_sync_corr dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_we_i   (we),
    .reg_rdata_o(rdata),
    .sync_i     (sync_i),
    .sync_o     (sync_o),
    .lock_o     (lock_o),
    .align_o    (align_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // scoreboard monitor: compares align/lock at each predicted boundary
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        chk("R6 align at boundary", {31'b0, align_o}, {31'b0, q[0].al});
        chk("R7 lock after boundary", {31'b0, lock_o}, {31'b0, q[0].lk});
        void'(q.pop_front());
      end else if (align_o) begin
        chk("R6 unexpected align", 32'd1, 32'd0);
      end
    end
  end

  // periods of the code; errs[p] chips flipped in period p
  task automatic stream(input int thr, input bit active, input int errs [6], input int np);
    int pos [5] = '{3, 10, 17, 24, 28};
    for (int p = 0; p < np; p++) begin
      for (int k = 0; k < 31; k++) begin
        bit b = code[k];
        for (int e = 0; e < errs[p]; e++) if (pos[e] == k) b = ~b;
        @(negedge clk);
        sync_i = b;
        if (k == 30) begin
          int sc = 16 - errs[p];
          bit hit = active && (sc >= thr);
          q.push_back('{cyc + 2, hit, hit});
        end
      end
    end
    @(negedge clk);
    sync_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int mism;
    for (int k = 0; k < 31; k++) code[k] = (k == 4);
    for (int k = 5; k < 31; k++) code[k] = code[k-5] ^ code[k-3];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl reset", {16'b0, d}, 32'h0);
    rd(2'd1, d); chk("R1 thr reset", {16'b0, d}, 32'd16);
    rd(2'd2, d); chk("R1 status reset", {16'b0, d}, 32'h0);
    chk("R1 outputs reset", {29'b0, sync_o, lock_o, align_o}, 32'h0);

    // R2 field widths
    wr(2'd1, 16'hFFEC); rd(2'd1, d); chk("R2 thr field", {16'b0, d}, 32'h0C);
    wr(2'd1, 16'd16);
    wr(2'd0, 16'hFFE0); rd(2'd0, d); chk("R2 ctrl unused bits", {16'b0, d}, 32'h0);

    // R4 master code: enable sync, pn, tx
    wr(2'd0, 16'h0013);
    mism = 0;
    for (int k = 0; k < 62; k++) begin
      if (sync_o !== code[k % 31]) begin
        mism++;
        $display("FAIL R4 chip %0d actual=%0b expected=%0b", k, sync_o, code[k % 31]);
      end
      @(negedge clk);
    end
    checks++; if (mism != 0) errors++;

    // R3 pulse mode blocks output
    wr(2'd0, 16'h0017);
    mism = 0;
    repeat (40) begin @(negedge clk); if (sync_o !== 1'b0) mism++; end
    chk("R3 pulse mode sync_o", mism, 0);
    wr(2'd0, 16'h0012);
    mism = 0;
    repeat (40) begin @(negedge clk); if (sync_o !== 1'b0) mism++; end
    chk("R3 feature off sync_o", mism, 0);
    wr(2'd0, 16'h0003);
    mism = 0;
    repeat (40) begin @(negedge clk); if (sync_o !== 1'b0) mism++; end
    chk("R4 tx disabled sync_o", mism, 0);

    // R5/R6 clean acquisition, R9 disable
    wr(2'd0, 16'h000B);
    stream(16, 1'b1, '{0, 0, 0, 0, 0, 0}, 3);
    rd(2'd2, d); chk("R5 locked status", {16'b0, d}, 32'h1);
    wr(2'd0, 16'h0000);
    rd(2'd2, d); chk("R9 disable no lost", {16'b0, d}, 32'h0);
    chk("R9 lock cleared", {31'b0, lock_o}, 32'h0);

    // R7/R8 threshold 16, one bad chip
    wr(2'd0, 16'h000B);
    stream(16, 1'b1, '{0, 0, 1, 0, 0, 0}, 5);
    rd(2'd2, d); chk("R8 lost sticky through relock", {16'b0, d}, 32'h3);
    wr(2'd0, 16'h0000);
    rd(2'd2, d); chk("R8 lost kept after disable", {16'b0, d}, 32'h2);
    wr(2'd2, 16'h0004);
    rd(2'd2, d); chk("R8 clear bit 1 alone", {16'b0, d}, 32'h6);
    wr(2'd2, 16'h0000);
    rd(2'd2, d); chk("R8 cleared after 1 then 0", {16'b0, d}, 32'h0);

    // R7 threshold 12 tolerance: 3,4 keep, 5 drop
    wr(2'd1, 16'd12);
    wr(2'd0, 16'h000B);
    stream(12, 1'b1, '{0, 3, 4, 5, 0, 0}, 6);
    rd(2'd2, d); chk("R7 relock and lost at thr 12", {16'b0, d}, 32'h3);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0004);
    wr(2'd2, 16'h0000);

    // R3 receive gating
    wr(2'd0, 16'h000A);
    stream(12, 1'b0, '{0, 0, 0, 0, 0, 0}, 2);
    rd(2'd2, d); chk("R3 no lock without enable", {16'b0, d}, 32'h0);
    wr(2'd0, 16'h000F);
    stream(12, 1'b0, '{0, 0, 0, 0, 0, 0}, 2);
    rd(2'd2, d); chk("R3 no lock in pulse mode", {16'b0, d}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule